// File: doc/BRIEF.md
# Sector Single-Bit Hamming ECC Checker

This block builds a 24-bit Hamming-style parity code over a flash sector as its bytes stream in. It then compares that code against the code that was stored with the sector. The running code is kept in inverted form. A sector that is all ones, as an erased page reads back, therefore produces an all-ones code. That code matches the all-ones bytes found in the spare area of an erased page, so an erased page checks clean.

Bytes arrive on a valid/ready stream. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The sender must hold `in_data` steady while `in_valid` is high and `in_ready` is low. `in_ready` is low while the sector already holds `SECTOR_BYTES` bytes, and during any cycle in which `start` or `cmp_req` is high. `start` clears the accumulator.

`cmp_req` does three things at once: it samples `stored_code`, it compares that code with the current `calc_code`, and it clears the accumulator. One cycle later `res_valid` pulses. At that point `status`, `err_byte` and `err_mask` hold the result, and they keep it until the next compare. Repairing the data buffer is left to the consumer, which uses the reported byte offset and bit mask.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `res_valid` is 0, `status`, `err_byte` and `err_mask` are 0, `in_ready` is 1 and `calc_code` is all ones.
- R2: Each data bit has a 12-bit address, formed as byte index times 8 plus bit position. For every address bit a, bit 12+a of the raw code is the XOR of the data bits whose address bit a is 1, and bit a of the raw code is the XOR of the data bits whose address bit a is 0. `calc_code` is the bitwise inverse of the raw code. Bits 7:0 of `calc_code` are the first byte of the serialized code. Example: a single byte 0x01 at index 0 gives 24'hFFF000.
- R3: A full sector of 0xFF bytes yields `calc_code` = 24'hFFFFFF.
- R4: `in_ready` is 0 when `SECTOR_BYTES` bytes have been taken, and when `start` or `cmp_req` is high. A byte that is not taken leaves `calc_code` unchanged.
- R5: `start` clears the accumulator, so `calc_code` is all ones on the next cycle and the byte index restarts at 0.
- R6: `res_valid` is high in exactly the cycle after each `cmp_req`. That `cmp_req` also clears the accumulator.
- R7: The difference is `calc_code` XOR `stored_code`. A zero difference gives status 0 (clean).
- R8: If difference bits 23:12 XOR bits 11:0 equal 12'hFFF, and the offset (difference bits 23:15) is below `SECTOR_BYTES`, the result is status 1 (data bit fixable). In that case `err_byte` is the offset and `err_mask` is 1 shifted left by difference bits 14:12.
- R9: A complementary difference whose offset is `SECTOR_BYTES` or more gives status 3 (uncorrectable).
- R10: A difference with exactly one bit set gives status 2 (fault in the stored code only), with `err_byte` and `err_mask` both 0.
- R11: Any other nonzero difference gives status 3, with `err_byte` and `err_mask` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear accumulator and restart at byte 0 |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| in_data | input | 8 | Stream byte |
| calc_code | output | 24 | Inverted running parity code |
| cmp_req | input | 1 | Compare request; also clears accumulator |
| stored_code | input | 24 | Code read back from flash, sampled on cmp_req |
| res_valid | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 clean, 1 data bit fixable, 2 code-only fault, 3 uncorrectable |
| err_byte | output | 9 | Byte offset of the bad bit (status 1 only) |
| err_mask | output | 8 | One-hot mask of the bad bit (status 1 only) |

## Verification
The bench builds the block with `SECTOR_BYTES` = 320. The code keeps its 24-bit layout because the byte index still needs 9 bits. Offsets from 320 to 511 can then be written into a complementary difference, which makes the out-of-range uncorrectable case reachable; with the default 512 it cannot occur. The smaller sector also keeps the full-sector back-pressure case and the erased-sector case short, and shows that an erased sector stays clean when the sector size is not a power of two.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int BIT_IDX_W = 3;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    ECC_CLEAN     = 2'd0,
    ECC_FIXABLE   = 2'd1,
    ECC_CODE_ONLY = 2'd2,
    ECC_FATAL     = 2'd3
  } ecc_status_e;

  // Bits b of a byte whose position has bit a set.
  function automatic logic [BYTE_BITS-1:0] col_mask(input int a);
    logic [BYTE_BITS-1:0] m;
    for (int b = 0; b < BYTE_BITS; b++) m[b] = ((b >> a) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int IDX_W        = 9,
  parameter int ADDR_W       = 12,
  parameter int CNT_W        = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  take,
  input  logic [BYTE_BITS-1:0]  data,
  output logic [CNT_W-1:0]      fill_cnt,
  output logic                  full,
  output logic [2*ADDR_W-1:0]   code_inv
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] odd_q, even_q;
  logic [ADDR_W-1:0] odd_d, even_d;
  logic [IDX_W-1:0]  row_odd, row_even;
  logic [BIT_IDX_W-1:0] col_odd, col_even;
  logic              byte_par;
  logic [IDX_W-1:0]  idx;

  assign byte_par = ^data;
  assign idx      = cnt_q[IDX_W-1:0];

  // Column parities: which bit positions inside the byte.
  for (genvar a = 0; a < BIT_IDX_W; a++) begin : g_col
    assign col_odd[a]  = ^(data &  col_mask(a));
    assign col_even[a] = ^(data & ~col_mask(a));
  end

  // Line parities: which byte index, whole-byte parity.
  for (genvar a = 0; a < IDX_W; a++) begin : g_row
    assign row_odd[a]  =  idx[a] & byte_par;
    assign row_even[a] = ~idx[a] & byte_par;
  end

  assign odd_d  = {row_odd,  col_odd};
  assign even_d = {row_even, col_even};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      odd_q  <= '0;
      even_q <= '0;
    end else if (clear) begin
      cnt_q  <= '0;
      odd_q  <= '0;
      even_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_q + 1'b1;
      odd_q  <= odd_q ^ odd_d;
      even_q <= even_q ^ even_d;
    end
  end

  assign fill_cnt = cnt_q;
  assign full     = (cnt_q >= CNT_W'(SECTOR_BYTES));
  assign code_inv = ~{odd_q, even_q};
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int IDX_W        = 9,
  parameter int ADDR_W       = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [2*ADDR_W-1:0]   calc,
  input  logic [2*ADDR_W-1:0]   stored,
  output logic                  res_valid,
  output logic [1:0]            status,
  output logic [IDX_W-1:0]      err_byte,
  output logic [BYTE_BITS-1:0]  err_mask
);
  logic [2*ADDR_W-1:0] diff;
  logic [ADDR_W-1:0]   hi, lo;
  logic [IDX_W-1:0]    off;
  logic                complementary, in_range, fixable;
  ecc_status_e         verdict;
  logic [BYTE_BITS-1:0] mask;

  assign diff          = calc ^ stored;
  assign hi            = diff[2*ADDR_W-1:ADDR_W];
  assign lo            = diff[ADDR_W-1:0];
  assign complementary = &(hi ^ lo);
  assign off           = hi[ADDR_W-1:BIT_IDX_W];
  assign in_range      = int'(off) < SECTOR_BYTES;
  assign fixable       = complementary && in_range;
  assign mask          = BYTE_BITS'(1) << hi[BIT_IDX_W-1:0];

  always_comb begin
    if (diff == '0)          verdict = ECC_CLEAN;
    else if (complementary)  verdict = in_range ? ECC_FIXABLE : ECC_FATAL;
    else if ($onehot(diff))  verdict = ECC_CODE_ONLY;
    else                     verdict = ECC_FATAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      status    <= '0;
      err_byte  <= '0;
      err_mask  <= '0;
    end else begin
      res_valid <= req;
      if (req) begin
        status   <= verdict;
        err_byte <= fixable ? off  : '0;
        err_mask <= fixable ? mask : '0;
      end
    end
  end
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = IDX_W + BIT_IDX_W,
  localparam int CODE_W = 2 * ADDR_W,
  localparam int CNT_W  = $clog2(SECTOR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic [CODE_W-1:0] calc_code,
  input  logic              cmp_req,
  input  logic [CODE_W-1:0] stored_code,
  output logic              res_valid,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  err_byte,
  output logic [7:0]        err_mask
);
  logic [CNT_W-1:0] fill_cnt;
  logic             full;
  logic             take;

  assign in_ready = !full && !start && !cmp_req;
  assign take     = in_valid && in_ready;

  hecc_accum #(
    .SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(start || cmp_req), .take(take),
    .data(in_data), .fill_cnt(fill_cnt), .full(full), .code_inv(calc_code)
  );

  hecc_classify #(
    .SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .req(cmp_req), .calc(calc_code),
    .stored(stored_code), .res_valid(res_valid), .status(status),
    .err_byte(err_byte), .err_mask(err_mask)
  );
endmodule

// File: rtl/hamming_sector_ecc_chk.sv
module hamming_sector_ecc_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int IDX_W  = 9,
  parameter int CODE_W = 24,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmp_req,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] calc_code,
  input logic              res_valid,
  input logic [1:0]        status,
  input logic [IDX_W-1:0]  err_byte,
  input logic [7:0]        err_mask,
  input logic [CNT_W-1:0]  fill_cnt
);
  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_cnt) >= SECTOR_BYTES) |-> !in_ready);

  p_idle_holds_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !start && !cmp_req) |=> $stable(calc_code));

  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (calc_code == {CODE_W{1'b1}}));

  p_strobe_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> res_valid);

  p_no_spurious_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> !res_valid);

  p_cmp_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> (calc_code == {CODE_W{1'b1}}));

  p_fix_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && status == 2'd1) |-> ($onehot(err_mask) && int'(err_byte) < SECTOR_BYTES));

  p_no_location_otherwise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && status != 2'd1) |-> (err_mask == '0 && err_byte == '0));
endmodule

bind hamming_sector_ecc hamming_sector_ecc_chk #(
  .SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmp_req(cmp_req),
  .in_valid(in_valid), .in_ready(in_ready), .calc_code(calc_code),
  .res_valid(res_valid), .status(status), .err_byte(err_byte),
  .err_mask(err_mask), .fill_cnt(fill_cnt)
);

// File: tb/tb_hamming_sector_ecc.sv
`timescale 1ns/1ps
module tb_hamming_sector_ecc;
  localparam int SB = 320;
  localparam int IW = 9;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, cmp_req = 1'b0;
  logic [7:0]  in_data = '0;
  logic [23:0] stored_code = '0;
  logic in_ready, res_valid;
  logic [23:0] calc_code;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [7:0]  err_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hamming_sector_ecc #(.SECTOR_BYTES(SB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .calc_code(calc_code),
    .cmp_req(cmp_req), .stored_code(stored_code), .res_valid(res_valid),
    .status(status), .err_byte(err_byte), .err_mask(err_mask)
  );

  // Behavioural reference model
  int        m_cnt = 0;
  bit [11:0] m_odd = '0, m_even = '0;
  bit        m_rv = 0;
  bit [1:0]  m_st = 0;
  bit [8:0]  m_eb = 0;
  bit [7:0]  m_em = 0;

  function automatic bit [23:0] m_code();
    return ~{m_odd, m_even};
  endfunction

  function automatic bit m_ready();
    return (m_cnt < SB) && !start && !cmp_req;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_odd = '0; m_even = '0; m_rv = 0; m_st = 0; m_eb = 0; m_em = 0;
    end else begin
      m_rv = cmp_req;
      if (cmp_req) begin
        int d;
        int off;
        d = int'(m_code() ^ stored_code);
        m_eb = 0; m_em = 0;
        if (d == 0) m_st = 0;
        else if ((((d >> 12) ^ d) & 12'hFFF) == 12'hFFF) begin
          off = d >> 15;
          if (off < SB) begin
            m_st = 1; m_eb = 9'(off); m_em = 8'(1 << ((d >> 12) & 7));
          end else m_st = 3;
        end else if ((d & (d - 1)) == 0) m_st = 2;
        else m_st = 3;
        m_cnt = 0; m_odd = '0; m_even = '0;
      end else if (start) begin
        m_cnt = 0; m_odd = '0; m_even = '0;
      end else if (in_valid && m_ready()) begin
        for (int b = 0; b < 8; b++) begin
          if (in_data[b]) begin
            int addr;
            addr = m_cnt * 8 + b;
            for (int a = 0; a < AW; a++) begin
              if ((addr >> a) & 1) m_odd[a] = ~m_odd[a];
              else                 m_even[a] = ~m_even[a];
            end
          end
        end
        m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(calc_code === m_code(), "R2 calc_code", calc_code, m_code());
    chk(in_ready === m_ready(), "R4 in_ready", in_ready, m_ready());
    chk(res_valid === m_rv, "R6 res_valid", res_valid, m_rv);
    chk(status === m_st, "R7/R8/R9/R10/R11 status", status, m_st);
    chk(err_byte === m_eb, "R8 err_byte", err_byte, m_eb);
    chk(err_mask === m_em, "R8 err_mask", err_mask, m_em);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  function automatic bit [7:0] gen(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + (i >> 3)) & 8'hFF);
  endfunction

  task automatic send(input bit [7:0] d);
    in_valid = 1'b1; in_data = d;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic send_sector(input int seed, input int fb0, input int fbit0,
                             input int fb1, input int fbit1, input bit erased);
    for (int i = 0; i < SB; i++) begin
      bit [7:0] d;
      d = erased ? 8'hFF : gen(i, seed);
      if (i == fb0) d ^= 8'(1 << fbit0);
      if (i == fb1) d ^= 8'(1 << fbit1);
      send(d);
      if ((i % 53) == 7) tick();
    end
  endtask

  task automatic do_cmp(input bit [23:0] s);
    cmp_req = 1'b1; stored_code = s;
    tick();
    cmp_req = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [23:0] w;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
    chk(status === 2'd0 && err_byte === '0 && err_mask === '0, "R1 result", status, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(calc_code === 24'hFFFFFF, "R1 calc_code", calc_code, 24'hFFFFFF);
    rst_n = 1'b1;
    tick();

    // R2 single byte layout
    send(8'h01);
    chk(calc_code === 24'hFFF000, "R2 single byte", calc_code, 24'hFFF000);
    do_start();
    chk(calc_code === 24'hFFFFFF, "R5 start clears", calc_code, 24'hFFFFFF);

    // R5 start mid-stream
    for (int i = 0; i < 5; i++) send(gen(i, 3));
    in_valid = 1'b1; in_data = 8'hA5; start = 1'b1;
    #1;
    chk(in_ready === 1'b0, "R4 ready low on start", in_ready, 0);
    tick();
    start = 1'b0; in_valid = 1'b0;
    chk(calc_code === 24'hFFFFFF, "R5 mid-stream clear", calc_code, 24'hFFFFFF);

    // R3 erased sector, R4 full back-pressure
    send_sector(0, -1, 0, -1, 0, 1'b1);
    chk(calc_code === 24'hFFFFFF, "R3 erased code", calc_code, 24'hFFFFFF);
    in_valid = 1'b1; in_data = 8'h00;
    repeat (3) tick();
    chk(in_ready === 1'b0, "R4 full sector", in_ready, 0);
    chk(calc_code === 24'hFFFFFF, "R4 ignored byte", calc_code, 24'hFFFFFF);
    in_valid = 1'b0;
    do_cmp(24'hFFFFFF);
    chk(res_valid === 1'b1 && status === 2'd0, "R7 erased clean", status, 0);
    tick();
    chk(res_valid === 1'b0, "R6 single pulse", res_valid, 0);
    chk(calc_code === 24'hFFFFFF, "R6 cmp clears", calc_code, 24'hFFFFFF);

    // Write pass, record code
    send_sector(1, -1, 0, -1, 0, 1'b0);
    w = calc_code;
    do_cmp(w);
    chk(status === 2'd0, "R7 same data", status, 0);

    // R8 one data bit flipped
    send_sector(1, 100, 5, -1, 0, 1'b0);
    do_cmp(w);
    chk(status === 2'd1 && err_byte === 9'd100 && err_mask === 8'h20,
        "R8 fix byte100 bit5", {status, err_byte, err_mask}, {2'd1, 9'd100, 8'h20});

    // R11 two data bits flipped
    send_sector(1, 3, 0, 200, 7, 1'b0);
    do_cmp(w);
    chk(status === 2'd3 && err_mask === 8'h00, "R11 two bits", status, 3);

    // R10 single bit in stored code (empty accumulator = all ones)
    do_cmp(24'hFFFFFF ^ 24'h020000);
    chk(status === 2'd2 && err_byte === '0 && err_mask === '0, "R10 code-only", status, 2);

    // R9 complementary difference, offset 400 out of range
    begin
      bit [11:0] a;
      a = {9'd400, 3'd2};
      do_cmp(24'hFFFFFF ^ {a, ~a});
      chk(status === 2'd3 && err_byte === '0, "R9 offset 400", status, 3);
      a = {9'd319, 3'd7};
      do_cmp(24'hFFFFFF ^ {a, ~a});
      chk(status === 2'd1 && err_byte === 9'd319 && err_mask === 8'h80,
          "R8 last byte", {status, err_byte, err_mask}, {2'd1, 9'd319, 8'h80});
      a = {9'd320, 3'd0};
      do_cmp(24'hFFFFFF ^ {a, ~a});
      chk(status === 2'd3, "R9 offset 320", status, 3);
    end

    // R11 arbitrary difference
    do_cmp(24'hFFFFFF ^ 24'h000C01);
    chk(status === 2'd3, "R11 random diff", status, 3);
    repeat (2) tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule